// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block watches three snooped bus streams: an instruction-fetch bus, a memory-access bus and an internal system bus. It raises a break request when a bus cycle meets a programmed condition. It has two channels, and each one works on its own. Each channel picks which bus it watches and compares that cycle's address against a value under a per-bit mask. It can also compare the data word under its own mask, taken from the memory-access or the internal data bus. Further optional filters cover the cycle type, the direction, the operand size and, on the internal bus, the master that started the cycle.

A break found on an instruction fetch can be taken before the instruction executes or after it. In the after case, the channel stores the address of the matched fetch. It holds it until a retire strobe reports that same address, and only then pulses the request. Each channel also has a sticky flag, so a debug monitor can see which channel fired until it writes a clear. A single write port programs the channel registers. Halting the processor and taking the exception are left to the logic around the block.

Top module: `bus_break_unit`

## Requirements
- R1: The two channels match independently. `match_flag[c]` belongs to channel c. `brk_req` is high in any cycle where at least one channel fires. Out of reset, all outputs and all registers are zero.
- R2: The channel's address value is written with `cfg_sel`=0 and its address mask with `cfg_sel`=1. A mask bit of 1 makes that address bit always count as equal. Every unmasked bit must be equal for a match.
- R3: The control word is written with `cfg_sel`=4. Control bits [2:1] pick the watched bus: 0 is the fetch bus, 1 the memory-access bus, 2 the internal bus, and 3 matches nothing. A channel only matches a cycle whose valid strobe is high on its chosen bus.
- R4: Control bit 12 turns data comparison on, and bit 13 picks the data bus (0 memory-access, 1 internal). The data value is written with `cfg_sel`=2 and the data mask with `cfg_sel`=3, where a mask bit of 1 ignores that bit. A data-checked match also needs the chosen bus's data-valid strobe in the same cycle.
- R5: Data comparison is skipped for instruction-fetch cycles.
- R6: Control bit 11 turns the master filter on, and bits [10:9] hold the master code: 0 CPU, 1 DMA controller, 2 audio/flash DMA, 3 Ethernet DMA. The filter applies only when the internal bus is chosen. On the other buses it is ignored.
- R7: Control bits [4:3] set the cycle type: 1 means fetch only, 2 means data access only, and 0 or 3 means either. Cycles on the fetch bus are fetches. Cycles on the other two buses are data accesses, so fetch-only never matches on the internal bus.
- R8: Control bits [6:5] set the direction: 1 means read only, 2 means write only, and 0 or 3 means either. Fetch cycles count as reads.
- R9: Control bits [8:7] set the size: 0 means any, 1 byte, 2 word, 3 longword. On the buses, the size code is 0 byte, 1 word, 2 longword. Fetch cycles count as longword.
- R10: A data match, or a fetch match with control bit 14 clear, drives `brk_req` high for exactly the one clock after the edge that sampled the cycle, with `brk_after` low.
- R11: A fetch match with control bit 14 set stores the fetch address and drives nothing at first. The first later `ret_valid` with an equal `ret_addr` drives `brk_req` and `brk_after` high for one clock and empties the store. A newer matched fetch replaces the stored one.
- R12: `match_flag[c]` is set when channel c fires and stays set until a write with `cfg_sel`=5 to that channel; the data written is ignored. A fire in the same cycle as the clear wins.
- R13: Control bit 0 enables the channel. A disabled channel never fires. Writing the control word drops a stored after-execution break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fb_valid | input | 1 | Fetch bus cycle present |
| fb_addr | input | 32 | Fetch bus address |
| mb_valid | input | 1 | Memory-access bus cycle present |
| mb_addr | input | 32 | Memory-access bus address |
| mb_write | input | 1 | Memory-access cycle is a write |
| mb_size | input | 2 | Memory-access operand size code |
| mb_dvalid | input | 1 | Memory-access data bus holds valid data |
| mb_data | input | 32 | Memory-access data bus |
| ib_valid | input | 1 | Internal bus cycle present |
| ib_addr | input | 32 | Internal bus address |
| ib_write | input | 1 | Internal cycle is a write |
| ib_size | input | 2 | Internal operand size code |
| ib_master | input | 2 | Internal cycle's initiating master code |
| ib_dvalid | input | 1 | Internal data bus holds valid data |
| ib_data | input | 32 | Internal data bus |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_addr | input | 32 | Fetch address of the retiring instruction |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 3 | Register addressed within the channel |
| cfg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | Break request pulse |
| brk_after | output | 1 | The pulse comes from an after-execution fetch break |
| match_flag | output | 2 | Sticky per-channel match flags |

## Verification
The assertions take for granted that the snooped buses present at most one cycle per clock on each bus. They also assume register writes and snooped cycles are sampled at the same clock edge, with no stall. The bench keeps to this: it drives each bus for exactly one clock at a time and puts every configuration write on its own clock. The only exception is the one test that deliberately lines a clear up with a fire. Retire strobes are given only the addresses the bench has chosen, so the single-entry store for after-execution breaks never sees a retire it cannot relate to a known fetch.

// File: rtl/brk_pkg.sv
// Package: shared types for the bus breakpoint comparator.
// Holds the channel control word layout, the bus-source code and the
// register select codes. The control word bit positions are visible to
// software, so the field order below is fixed.
package brk_pkg;

    // Bus a channel watches for its address.
    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_MEM   = 2'd1,
        SRC_IBUS  = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    // Channel control word, MSB first: bit 14 down to bit 0.
    typedef struct packed {
        logic       post_exec;   // fetch break taken after execution
        logic       dsrc_ibus;   // data source: 1 internal, 0 memory-access
        logic       dcmp_en;     // data comparison enable
        logic       mst_en;      // bus master filter enable
        logic [1:0] mst_code;    // required master code
        logic [1:0] size_f;      // 0 any, 1 byte, 2 word, 3 longword
        logic [1:0] dir_f;       // 0/3 any, 1 read, 2 write
        logic [1:0] type_f;      // 0/3 any, 1 fetch, 2 data access
        src_e       src;         // watched bus
        logic       en;          // channel enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Register select codes on the write port.
    localparam logic [2:0] REG_AVAL  = 3'd0;
    localparam logic [2:0] REG_AMASK = 3'd1;
    localparam logic [2:0] REG_DVAL  = 3'd2;
    localparam logic [2:0] REG_DMASK = 3'd3;
    localparam logic [2:0] REG_CTRL  = 3'd4;
    localparam logic [2:0] REG_CLR   = 3'd5;

    // Size code used for instruction fetches (bus code for longword).
    localparam logic [1:0] SZ_FETCH = 2'd2;

endpackage

// File: rtl/brk_regs.sv
// Module: brk_regs
// Holds the per-channel compare values, masks and control words, and
// decodes the write port into per-channel register updates. It also
// produces one-cycle strobes for "control rewritten" and "flag clear".
// Assumes at most one write per clock; all registers reset to zero.
module brk_regs #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we_i,
    input  logic [CH_W-1:0]                    cfg_ch_i,
    input  logic [2:0]                         cfg_sel_i,
    input  logic [REG_W-1:0]                   cfg_wdata_i,
    output logic [NUM_CH-1:0][ADDR_W-1:0]      aval_o,
    output logic [NUM_CH-1:0][ADDR_W-1:0]      amask_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]      dval_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]      dmask_o,
    output brk_pkg::ctrl_t [NUM_CH-1:0]        ctrl_o,
    output logic [NUM_CH-1:0]                  ctrl_wr_o,
    output logic [NUM_CH-1:0]                  clr_o
);
    import brk_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = cfg_we_i && (cfg_ch_i == CH_W'(c));

        // Update the addressed register of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aval_o[c]  <= '0;
                amask_o[c] <= '0;
                dval_o[c]  <= '0;
                dmask_o[c] <= '0;
                ctrl_o[c]  <= '0;
            end else if (sel_me) begin
                case (cfg_sel_i)
                    REG_AVAL:  aval_o[c]  <= cfg_wdata_i[ADDR_W-1:0];
                    REG_AMASK: amask_o[c] <= cfg_wdata_i[ADDR_W-1:0];
                    REG_DVAL:  dval_o[c]  <= cfg_wdata_i[DATA_W-1:0];
                    REG_DMASK: dmask_o[c] <= cfg_wdata_i[DATA_W-1:0];
                    REG_CTRL:  ctrl_o[c]  <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end

        // Strobes for the channel's timing and flag logic.
        assign ctrl_wr_o[c] = sel_me && (cfg_sel_i == REG_CTRL);
        assign clr_o[c]     = sel_me && (cfg_sel_i == REG_CLR);
    end

endmodule

// File: rtl/brk_bus_view.sv
// Module: brk_bus_view
// Picks one snooped bus for a channel and presents its cycle as a common
// descriptor. Fetch-bus cycles are fetches, reads, longword-sized. The
// master code is meaningful only for the internal bus, and v_ibus_o says
// so. The data word comes from the channel's own data source choice,
// which is independent of the address bus choice. Purely combinational.
module brk_bus_view #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  brk_pkg::src_e       src_i,
    input  logic                dsrc_ibus_i,
    input  logic                fb_valid_i,
    input  logic [ADDR_W-1:0]   fb_addr_i,
    input  logic                mb_valid_i,
    input  logic [ADDR_W-1:0]   mb_addr_i,
    input  logic                mb_write_i,
    input  logic [1:0]          mb_size_i,
    input  logic                mb_dvalid_i,
    input  logic [DATA_W-1:0]   mb_data_i,
    input  logic                ib_valid_i,
    input  logic [ADDR_W-1:0]   ib_addr_i,
    input  logic                ib_write_i,
    input  logic [1:0]          ib_size_i,
    input  logic [1:0]          ib_master_i,
    input  logic                ib_dvalid_i,
    input  logic [DATA_W-1:0]   ib_data_i,
    output logic                v_valid_o,
    output logic [ADDR_W-1:0]   v_addr_o,
    output logic                v_fetch_o,
    output logic                v_write_o,
    output logic [1:0]          v_size_o,
    output logic                v_ibus_o,
    output logic [1:0]          v_master_o,
    output logic                v_dvalid_o,
    output logic [DATA_W-1:0]   v_data_o
);
    import brk_pkg::*;

    // Route the chosen address-side bus into the descriptor.
    always_comb begin
        v_valid_o  = 1'b0;
        v_addr_o   = '0;
        v_fetch_o  = 1'b0;
        v_write_o  = 1'b0;
        v_size_o   = '0;
        v_ibus_o   = 1'b0;
        v_master_o = '0;
        case (src_i)
            SRC_FETCH: begin
                v_valid_o = fb_valid_i;
                v_addr_o  = fb_addr_i;
                v_fetch_o = 1'b1;
                v_size_o  = SZ_FETCH;
            end
            SRC_MEM: begin
                v_valid_o = mb_valid_i;
                v_addr_o  = mb_addr_i;
                v_write_o = mb_write_i;
                v_size_o  = mb_size_i;
            end
            SRC_IBUS: begin
                v_valid_o  = ib_valid_i;
                v_addr_o   = ib_addr_i;
                v_write_o  = ib_write_i;
                v_size_o   = ib_size_i;
                v_ibus_o   = 1'b1;
                v_master_o = ib_master_i;
            end
            default: ;
        endcase
    end

    // Route the chosen data bus.
    always_comb begin
        v_dvalid_o = dsrc_ibus_i ? ib_dvalid_i : mb_dvalid_i;
        v_data_o   = dsrc_ibus_i ? ib_data_i   : mb_data_i;
    end

endmodule

// File: rtl/brk_channel.sv
// Module: brk_channel
// One break channel. It evaluates every condition field against the
// descriptor from brk_bus_view and timestamps the result: either an
// immediate one-cycle fire, or a single stored fetch address that waits
// for a matching retire strobe. It keeps the channel's sticky flag.
// Assumes one descriptor per clock and a retire strobe that carries the
// fetch address of the retiring instruction.
module brk_channel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  brk_pkg::ctrl_t      ctrl_i,
    input  logic [ADDR_W-1:0]   aval_i,
    input  logic [ADDR_W-1:0]   amask_i,
    input  logic [DATA_W-1:0]   dval_i,
    input  logic [DATA_W-1:0]   dmask_i,
    input  logic                ctrl_wr_i,
    input  logic                clr_i,
    input  logic                v_valid_i,
    input  logic [ADDR_W-1:0]   v_addr_i,
    input  logic                v_fetch_i,
    input  logic                v_write_i,
    input  logic [1:0]          v_size_i,
    input  logic                v_ibus_i,
    input  logic [1:0]          v_master_i,
    input  logic                v_dvalid_i,
    input  logic [DATA_W-1:0]   v_data_i,
    input  logic                ret_valid_i,
    input  logic [ADDR_W-1:0]   ret_addr_i,
    output logic                fire_pre_o,
    output logic                fire_post_o,
    output logic                flag_o
);
    import brk_pkg::*;

    logic addr_ok, data_ok, type_ok, dir_ok, size_ok, mst_ok, hit;
    logic take_pre, take_post, ret_hit;
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;

    // Per-field condition evaluation on the current descriptor.
    always_comb begin
        addr_ok = ((v_addr_i ^ aval_i) & ~amask_i) == '0;
        case (ctrl_i.type_f)
            2'd1:    type_ok = v_fetch_i;
            2'd2:    type_ok = !v_fetch_i;
            default: type_ok = 1'b1;
        endcase
        case (ctrl_i.dir_f)
            2'd1:    dir_ok = !v_write_i;
            2'd2:    dir_ok = v_write_i;
            default: dir_ok = 1'b1;
        endcase
        size_ok = (ctrl_i.size_f == 2'd0) ||
                  (ctrl_i.size_f == 2'(v_size_i + 2'd1));
        mst_ok  = !ctrl_i.mst_en || !v_ibus_i ||
                  (v_master_i == ctrl_i.mst_code);
        data_ok = !ctrl_i.dcmp_en || v_fetch_i ||
                  (v_dvalid_i && (((v_data_i ^ dval_i) & ~dmask_i) == '0));
        hit     = ctrl_i.en && v_valid_i && addr_ok && type_ok && dir_ok &&
                  size_ok && mst_ok && data_ok;
    end

    // Split a hit into the immediate or the after-execution path.
    always_comb begin
        take_post = hit && v_fetch_i && ctrl_i.post_exec;
        take_pre  = hit && !take_post;
        ret_hit   = pend_v && ret_valid_i && (ret_addr_i == pend_addr);
    end

    // Single-entry store for an after-execution fetch break.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_i.en || ctrl_wr_i) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
        end else if (take_post) begin
            pend_v    <= 1'b1;
            pend_addr <= v_addr_i;
        end else if (ret_hit) begin
            pend_v    <= 1'b0;
        end
    end

    // One-cycle fire registers, one per timing path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_pre_o  <= 1'b0;
            fire_post_o <= 1'b0;
        end else begin
            fire_pre_o  <= take_pre;
            fire_post_o <= ret_hit && ctrl_i.en;
        end
    end

    // Sticky flag: a fire sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (take_pre || (ret_hit && ctrl_i.en))
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R12: without a clear, a set flag stays set.
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R12: any fire is reflected in the flag.
    a_r12_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_pre_o || fire_post_o) |-> flag_o);

    // R11: an after-execution fire needs a stored fetch the cycle before.
    a_r11_post_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fire_post_o |-> $past(pend_v));

    // R13: a disabled channel fires nothing on the next cycle.
    a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.en |=> !(fire_pre_o || fire_post_o));

    // R7: fetch-only conditions never hit on the internal bus.
    a_r7_no_ibus_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !(ctrl_i.src == SRC_IBUS && ctrl_i.type_f == 2'd1));

endmodule

// File: rtl/bus_break_unit.sv
// Module: bus_break_unit (top)
// Two-channel hardware breakpoint comparator. It snoops the fetch,
// memory-access and internal buses and raises a break request when a
// channel's condition is met. There is one view and one channel per
// break channel, plus a shared register bank.
// Assumes the snooped buses give at most one cycle per clock each.
module bus_break_unit #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_valid,
    input  logic [ADDR_W-1:0] fb_addr,
    input  logic              mb_valid,
    input  logic [ADDR_W-1:0] mb_addr,
    input  logic              mb_write,
    input  logic [1:0]        mb_size,
    input  logic              mb_dvalid,
    input  logic [DATA_W-1:0] mb_data,
    input  logic              ib_valid,
    input  logic [ADDR_W-1:0] ib_addr,
    input  logic              ib_write,
    input  logic [1:0]        ib_size,
    input  logic [1:0]        ib_master,
    input  logic              ib_dvalid,
    input  logic [DATA_W-1:0] ib_data,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              brk_req,
    output logic              brk_after,
    output logic [NUM_CH-1:0] match_flag
);
    import brk_pkg::*;

    logic [NUM_CH-1:0][ADDR_W-1:0] aval, amask;
    logic [NUM_CH-1:0][DATA_W-1:0] dval, dmask;
    ctrl_t [NUM_CH-1:0]            ctrl;
    logic [NUM_CH-1:0]             ctrl_wr, clr, fire_pre, fire_post;

    brk_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata),
        .aval_o(aval), .amask_o(amask), .dval_o(dval), .dmask_o(dmask),
        .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr), .clr_o(clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              v_valid, v_fetch, v_write, v_ibus, v_dvalid;
        logic [ADDR_W-1:0] v_addr;
        logic [1:0]        v_size, v_master;
        logic [DATA_W-1:0] v_data;

        brk_bus_view #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_view (
            .src_i(ctrl[c].src), .dsrc_ibus_i(ctrl[c].dsrc_ibus),
            .fb_valid_i(fb_valid), .fb_addr_i(fb_addr),
            .mb_valid_i(mb_valid), .mb_addr_i(mb_addr),
            .mb_write_i(mb_write), .mb_size_i(mb_size),
            .mb_dvalid_i(mb_dvalid), .mb_data_i(mb_data),
            .ib_valid_i(ib_valid), .ib_addr_i(ib_addr),
            .ib_write_i(ib_write), .ib_size_i(ib_size),
            .ib_master_i(ib_master), .ib_dvalid_i(ib_dvalid),
            .ib_data_i(ib_data),
            .v_valid_o(v_valid), .v_addr_o(v_addr), .v_fetch_o(v_fetch),
            .v_write_o(v_write), .v_size_o(v_size), .v_ibus_o(v_ibus),
            .v_master_o(v_master), .v_dvalid_o(v_dvalid), .v_data_o(v_data)
        );

        brk_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .ctrl_i(ctrl[c]), .aval_i(aval[c]), .amask_i(amask[c]),
            .dval_i(dval[c]), .dmask_i(dmask[c]),
            .ctrl_wr_i(ctrl_wr[c]), .clr_i(clr[c]),
            .v_valid_i(v_valid), .v_addr_i(v_addr), .v_fetch_i(v_fetch),
            .v_write_i(v_write), .v_size_i(v_size), .v_ibus_i(v_ibus),
            .v_master_i(v_master), .v_dvalid_i(v_dvalid), .v_data_i(v_data),
            .ret_valid_i(ret_valid), .ret_addr_i(ret_addr),
            .fire_pre_o(fire_pre[c]), .fire_post_o(fire_post[c]),
            .flag_o(match_flag[c])
        );
    end

    // Merge channel fires into the shared request outputs.
    always_comb begin
        brk_req   = |{fire_pre, fire_post};
        brk_after = |fire_post;
    end

    // R1: a request always comes with at least one channel flag set.
    a_r1_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (match_flag != '0));

endmodule

// File: tb/sim_bus_break_unit.sv
// Self-checking bench: near-exhaustive sweeps of each condition field on a
// two-channel configuration. Expected values are derived from the
// requirement encodings.
module sim_bus_break_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fb_valid, mb_valid, mb_write, mb_dvalid;
    logic        ib_valid, ib_write, ib_dvalid, ret_valid, cfg_we;
    logic [31:0] fb_addr, mb_addr, mb_data, ib_addr, ib_data, ret_addr, cfg_wdata;
    logic [1:0]  mb_size, ib_size, ib_master;
    logic [0:0]  cfg_ch;
    logic [2:0]  cfg_sel;
    logic        brk_req, brk_after;
    logic [1:0]  match_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_break_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .fb_valid(fb_valid), .fb_addr(fb_addr),
        .mb_valid(mb_valid), .mb_addr(mb_addr), .mb_write(mb_write),
        .mb_size(mb_size), .mb_dvalid(mb_dvalid), .mb_data(mb_data),
        .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_write(ib_write),
        .ib_size(ib_size), .ib_master(ib_master), .ib_dvalid(ib_dvalid),
        .ib_data(ib_data), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata),
        .brk_req(brk_req), .brk_after(brk_after), .match_flag(match_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        fb_valid = 0; mb_valid = 0; ib_valid = 0;
        mb_dvalid = 0; ib_dvalid = 0; ret_valid = 0;
        mb_write = 0; ib_write = 0; mb_size = 2; ib_size = 2; ib_master = 0;
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_ch = 1'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Build a control word from the field encodings in R3..R13.
    function automatic logic [31:0] mk(input int en, input int src, input int typ,
            input int dir, input int sz, input int me, input int mc,
            input int dc, input int ds, input int po);
        return 32'(en) | (32'(src) << 1) | (32'(typ) << 3) | (32'(dir) << 5) |
               (32'(sz) << 7) | (32'(mc) << 9) | (32'(me) << 11) |
               (32'(dc) << 12) | (32'(ds) << 13) | (32'(po) << 14);
    endfunction

    // Drive one cycle on bus (0 fetch, 1 mem, 2 internal); on return the
    // fire register for that cycle is visible.
    task automatic probe(input int bus, input logic [31:0] a, input logic w,
            input logic [1:0] sz, input logic [1:0] m,
            input logic mdv, input logic [31:0] md,
            input logic idv, input logic [31:0] id);
        @(negedge clk);
        case (bus)
            0: begin fb_valid = 1; fb_addr = a; end
            1: begin mb_valid = 1; mb_addr = a; mb_write = w; mb_size = sz; end
            default: begin ib_valid = 1; ib_addr = a; ib_write = w;
                           ib_size = sz; ib_master = m; end
        endcase
        mb_dvalid = mdv; mb_data = md; ib_dvalid = idv; ib_data = id;
        @(negedge clk);
        idle();
    endtask

    task automatic simple(input int bus, input logic [31:0] a);
        probe(bus, a, 0, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic retire(input logic [31:0] a);
        @(negedge clk);
        ret_valid = 1; ret_addr = a;
        @(negedge clk);
        ret_valid = 0;
    endtask

    localparam logic [31:0] A = 32'h1234_5678;
    localparam logic [31:0] D = 32'hCAFE_0042;

    initial begin
        rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_wdata = 0;
        fb_addr = 0; mb_addr = 0; ib_addr = 0; mb_data = 0; ib_data = 0; ret_addr = 0;
        idle();
        repeat (4) @(negedge clk);
        chk("R1 reset brk_req", 32'(brk_req), 0);
        chk("R1 reset flags", 32'(match_flag), 0);
        chk("R1 reset brk_after", 32'(brk_after), 0);
        rst_n = 1;
        @(negedge clk);

        // R13: enable clear blocks matches.
        wr(0, 0, A);
        wr(0, 4, mk(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        simple(1, A);
        chk("R13 disabled channel", 32'(brk_req), 0);

        // R2: sweep every address bit under an alternating mask.
        wr(0, 1, 32'hAAAA_AAAA);
        wr(0, 4, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        simple(1, A);
        chk("R2 exact address", 32'(brk_req), 1);
        for (int i = 0; i < 32; i++) begin
            simple(1, A ^ (32'd1 << i));
            chk($sformatf("R2 bit %0d", i), 32'(brk_req), 32'((32'hAAAA_AAAA >> i) & 1));
        end
        wr(0, 1, 0);

        // R3: bus source select sweep.
        for (int s = 0; s < 4; s++) begin
            wr(0, 4, mk(1, s, 0, 0, 0, 0, 0, 0, 0, 0));
            for (int b = 0; b < 3; b++) begin
                simple(b, A);
                chk($sformatf("R3 src %0d bus %0d", s, b), 32'(brk_req), 32'(s == b));
            end
        end

        // R7: cycle type against each bus.
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < 4; t++) begin
                wr(0, 4, mk(1, s, t, 0, 0, 0, 0, 0, 0, 0));
                simple(s, A);
                chk($sformatf("R7 src %0d type %0d", s, t), 32'(brk_req),
                    32'(t == 0 || t == 3 || (t == 1 && s == 0) || (t == 2 && s != 0)));
            end

        // R9: size field against bus size codes, plus fetch as longword.
        for (int f = 0; f < 4; f++) begin
            wr(0, 4, mk(1, 1, 0, 0, f, 0, 0, 0, 0, 0));
            for (int s = 0; s < 3; s++) begin
                probe(1, A, 0, 2'(s), 0, 0, 0, 0, 0);
                chk($sformatf("R9 field %0d size %0d", f, s), 32'(brk_req),
                    32'(f == 0 || f == s + 1));
            end
            wr(0, 4, mk(1, 0, 0, 0, f, 0, 0, 0, 0, 0));
            simple(0, A);
            chk($sformatf("R9 fetch size field %0d", f), 32'(brk_req), 32'(f == 0 || f == 3));
        end

        // R8: direction field against reads and writes, fetch as read.
        for (int f = 0; f < 4; f++) begin
            wr(0, 4, mk(1, 2, 0, f, 0, 0, 0, 0, 0, 0));
            for (int w = 0; w < 2; w++) begin
                probe(2, A, 1'(w), 2, 0, 0, 0, 0, 0);
                chk($sformatf("R8 field %0d write %0d", f, w), 32'(brk_req),
                    32'(f == 0 || f == 3 || (f == 1 && w == 0) || (f == 2 && w == 1)));
            end
            wr(0, 4, mk(1, 0, 0, f, 0, 0, 0, 0, 0, 0));
            simple(0, A);
            chk($sformatf("R8 fetch dir field %0d", f), 32'(brk_req), 32'(f != 2));
        end

        // R6: master filter sweep on the internal bus, ignored elsewhere.
        for (int e = 0; e < 2; e++)
            for (int c = 0; c < 4; c++) begin
                wr(0, 4, mk(1, 2, 0, 0, 0, e, c, 0, 0, 0));
                for (int m = 0; m < 4; m++) begin
                    probe(2, A, 0, 2, 2'(m), 0, 0, 0, 0);
                    chk($sformatf("R6 en %0d code %0d master %0d", e, c, m),
                        32'(brk_req), 32'(e == 0 || c == m));
                end
            end
        wr(0, 4, mk(1, 1, 0, 0, 0, 1, 3, 0, 0, 0));
        simple(1, A);
        chk("R6 filter ignored on memory bus", 32'(brk_req), 1);

        // R4: data comparison, memory source then internal source.
        wr(0, 2, D);
        wr(0, 3, 32'h0000_00FF);
        wr(0, 4, mk(1, 1, 0, 0, 0, 0, 0, 1, 0, 0));
        probe(1, A, 0, 2, 0, 0, D, 0, 0);
        chk("R4 no data valid", 32'(brk_req), 0);
        probe(1, A, 0, 2, 0, 1, D, 0, 0);
        chk("R4 data equal", 32'(brk_req), 1);
        probe(1, A, 0, 2, 0, 1, D ^ 32'h01, 0, 0);
        chk("R4 masked data bit", 32'(brk_req), 1);
        probe(1, A, 0, 2, 0, 1, D ^ 32'h100, 0, 0);
        chk("R4 unmasked data bit", 32'(brk_req), 0);
        probe(1, A, 0, 2, 0, 1, ~D, 1, D);
        chk("R4 wrong data bus ignored", 32'(brk_req), 0);
        wr(0, 4, mk(1, 1, 0, 0, 0, 0, 0, 1, 1, 0));
        probe(1, A, 0, 2, 0, 1, ~D, 1, D);
        chk("R4 internal data source", 32'(brk_req), 1);
        probe(1, A, 0, 2, 0, 1, D, 0, D);
        chk("R4 internal data not valid", 32'(brk_req), 0);

        // R5: data condition skipped for fetch cycles.
        wr(0, 4, mk(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        probe(0, A, 0, 2, 0, 0, ~D, 0, ~D);
        chk("R5 fetch skips data", 32'(brk_req), 1);

        // R10: before-execution fetch break pulses once.
        wr(0, 4, mk(1, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        simple(0, A);
        chk("R10 pre fetch req", 32'(brk_req), 1);
        chk("R10 pre fetch after flag", 32'(brk_after), 0);
        @(negedge clk);
        chk("R10 single pulse", 32'(brk_req), 0);

        // R11: after-execution break waits for the matching retire.
        wr(0, 4, mk(1, 0, 1, 0, 0, 0, 0, 0, 0, 1));
        simple(0, A);
        chk("R11 no req at fetch", 32'(brk_req), 0);
        retire(A + 4);
        chk("R11 other retire", 32'(brk_req), 0);
        retire(A);
        chk("R11 req on retire", 32'(brk_req), 1);
        chk("R11 after flag", 32'(brk_after), 1);
        retire(A);
        chk("R11 store emptied", 32'(brk_req), 0);
        wr(0, 1, 32'h0000_00F0);
        simple(0, A);
        simple(0, A ^ 32'h10);
        retire(A);
        chk("R11 replaced entry old", 32'(brk_req), 0);
        retire(A ^ 32'h10);
        chk("R11 replaced entry new", 32'(brk_req), 1);
        // R13: a control rewrite drops the stored break.
        simple(0, A);
        wr(0, 4, mk(1, 0, 1, 0, 0, 0, 0, 0, 0, 1));
        retire(A);
        chk("R13 rewrite drops pending", 32'(brk_req), 0);
        wr(0, 1, 0);

        // R1/R12: independent channels and sticky flags.
        wr(0, 5, 0);
        wr(1, 5, 0);
        wr(0, 4, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(1, 0, 32'h0000_4000);
        wr(1, 4, mk(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
        simple(1, A);
        chk("R1 only channel 0", 32'(match_flag), 32'b01);
        simple(2, 32'h0000_4000);
        chk("R1 channel 1 req", 32'(brk_req), 1);
        chk("R1 both flags", 32'(match_flag), 32'b11);
        repeat (5) @(negedge clk);
        chk("R12 flags held", 32'(match_flag), 32'b11);
        wr(0, 5, 32'hFFFF_FFFF);
        chk("R12 clear channel 0 only", 32'(match_flag), 32'b10);
        // R12: fire and clear in one cycle, set wins.
        @(negedge clk);
        cfg_we = 1; cfg_ch = 0; cfg_sel = 5;
        mb_valid = 1; mb_addr = A;
        @(negedge clk);
        cfg_we = 0; idle();
        chk("R12 set wins over clear", 32'(match_flag), 32'b11);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule